// File: doc/BRIEF.md
# Four-Context Round-Robin Issue Scheduler

This block sits in front of the issue stage of a core that runs four hardware thread contexts. On every clock cycle it decides which single context owns the issue slot. Each context reports whether it has an instruction ready. Each context also reports whether a second independent instruction could issue alongside the first. The scheduler answers with a one-hot grant, the index of the granted context, an issue strobe for each of the two execution pipes, and an idle flag for cycles in which nothing issues.

The search is round-robin. It starts at the context after the one most recently granted. The context that won in the previous cycle is barred from the current cycle, so a context can never hold the slot twice in a row. With only one context ready, the core issues at most every other cycle. Two or more ready contexts keep the slot busy on every cycle.

All outputs are registered. The ready and dual flags sampled at a rising edge appear as a decision on the outputs just after that same edge.

Top module: `ts_issue_sched`

## Requirements
- R1: While `rst` is high at a rising edge, the block drives `grant_onehot` = 0, `grant_id` = 0, both pipe strobes low and `core_idle` high on the next cycle. The internal pointer returns to context 3 and the bar on a previous winner is cleared.
- R2: Suppose context k was the last one granted and is barred. The block then searches contexts k+1, k+2 and k+3 (mod 4) in that order and grants the first whose `thr_ready` bit is set. If no context is barred, context k itself is searched last, as position k+4. After reset, context 0 is searched first.
- R3: No context is granted in two consecutive cycles, even when it is the only ready context.
- R4: When a single context is held ready, its grants alternate with idle cycles.
- R5: When two or more bits of `thr_ready` are set at an edge, a grant is made for that edge.
- R6: `grant_onehot` has at most one bit set. `grant_id` gives the binary index of that bit. `core_idle` is high exactly when `grant_onehot` is zero.
- R7: `pipe0_issue` is high exactly when a grant is made. `pipe1_issue` is high only when `pipe0_issue` is high and the `thr_dual` bit of the granted context was set at the deciding edge.
- R8: A context whose `thr_ready` bit is low is never granted. It is skipped without using up a search position.
- R9: A cycle with no grant leaves the last-granted pointer unchanged and lifts the bar on the previous winner. The same context may then be granted on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| thr_ready | input | NUM_THREADS | Bit t set: context t has an instruction to issue |
| thr_dual | input | NUM_THREADS | Bit t set: context t can also issue a second instruction on pipe 1 |
| grant_onehot | output | NUM_THREADS | Registered one-hot grant, zero when idle |
| grant_id | output | $clog2(NUM_THREADS) | Registered index of the granted context |
| pipe0_issue | output | 1 | Registered issue strobe for pipe 0 |
| pipe1_issue | output | 1 | Registered issue strobe for pipe 1 |
| core_idle | output | 1 | Registered flag: no context granted this cycle |

## Verification
The bar on the previous winner and the idle path can act in the same cycle. When a lone ready context is held steady, the bar is the very reason the cycle goes idle, and that idle cycle must then lift the bar. Otherwise the context would starve. The bench provokes this by holding each context alone for several cycles. It judges the result by strict grant and idle alternation, and it also checks that a grant follows at once after an idle gap. An exhaustive sweep over all ready and dual patterns, compared against an arithmetic rotation model, covers the same collision reached from every pointer position.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int SCHED_THREADS = 4;
endpackage

// File: rtl/ts_elig_mask.sv
module ts_elig_mask #(
  parameter int N   = 4,
  parameter int IDW = $clog2(N)
) (
  input  logic [N-1:0]   ready,
  input  logic [IDW-1:0] last_ptr,
  input  logic           bar_valid,
  output logic [N-1:0]   elig
);
  for (genvar t = 0; t < N; t++) begin : g_ctx
    assign elig[t] = ready[t] && !(bar_valid && (last_ptr == IDW'(t)));
  end
endmodule

// File: rtl/ts_rr_pick.sv
module ts_rr_pick #(
  parameter int N   = 4,
  parameter int IDW = $clog2(N)
) (
  input  logic [N-1:0]   elig,
  input  logic [IDW-1:0] last_ptr,
  output logic [N-1:0]   pick_onehot,
  output logic [IDW-1:0] pick_id,
  output logic           pick_any
);
  always_comb begin
    pick_onehot = '0;
    pick_id     = '0;
    pick_any    = 1'b0;
    // offsets 1..N walk the ring starting just past the last winner
    for (int off = 1; off <= N; off++) begin
      int t;
      t = (int'(last_ptr) + off) % N;
      if (!pick_any && elig[t]) begin
        pick_any       = 1'b1;
        pick_onehot[t] = 1'b1;
        pick_id        = IDW'(t);
      end
    end
  end
endmodule

// File: rtl/ts_history.sv
module ts_history #(
  parameter int N   = 4,
  parameter int IDW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pick_any,
  input  logic [IDW-1:0] pick_id,
  output logic [IDW-1:0] last_ptr,
  output logic           bar_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      last_ptr  <= IDW'(N - 1);
      bar_valid <= 1'b0;
    end else if (pick_any) begin
      last_ptr  <= pick_id;
      bar_valid <= 1'b1;
    end else begin
      bar_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ts_issue_sched.sv
module ts_issue_sched #(
  parameter  int NUM_THREADS = ts_pkg::SCHED_THREADS,
  localparam int IDW         = $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_THREADS-1:0] thr_ready,
  input  logic [NUM_THREADS-1:0] thr_dual,
  output logic [NUM_THREADS-1:0] grant_onehot,
  output logic [IDW-1:0]         grant_id,
  output logic                   pipe0_issue,
  output logic                   pipe1_issue,
  output logic                   core_idle
);
  logic [IDW-1:0]         last_ptr;
  logic                   bar_valid;
  logic [NUM_THREADS-1:0] elig;
  logic [NUM_THREADS-1:0] pick_onehot;
  logic [IDW-1:0]         pick_id;
  logic                   pick_any;

  ts_elig_mask #(.N(NUM_THREADS), .IDW(IDW)) u_mask (
    .ready(thr_ready), .last_ptr(last_ptr), .bar_valid(bar_valid), .elig(elig)
  );

  ts_rr_pick #(.N(NUM_THREADS), .IDW(IDW)) u_pick (
    .elig(elig), .last_ptr(last_ptr),
    .pick_onehot(pick_onehot), .pick_id(pick_id), .pick_any(pick_any)
  );

  ts_history #(.N(NUM_THREADS), .IDW(IDW)) u_hist (
    .clk(clk), .rst(rst), .pick_any(pick_any), .pick_id(pick_id),
    .last_ptr(last_ptr), .bar_valid(bar_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_onehot <= '0;
      grant_id     <= '0;
      pipe0_issue  <= 1'b0;
      pipe1_issue  <= 1'b0;
      core_idle    <= 1'b1;
    end else begin
      grant_onehot <= pick_onehot;
      grant_id     <= pick_id;
      pipe0_issue  <= pick_any;
      pipe1_issue  <= pick_any && thr_dual[pick_id];
      core_idle    <= !pick_any;
    end
  end
endmodule

// File: rtl/ts_issue_sched_chk.sv
module ts_issue_sched_chk #(
  parameter int N   = 4,
  parameter int IDW = $clog2(N)
) (
  input logic           clk,
  input logic           rst,
  input logic [N-1:0]   thr_ready,
  input logic [N-1:0]   thr_dual,
  input logic [N-1:0]   grant_onehot,
  input logic [IDW-1:0] grant_id,
  input logic           pipe0_issue,
  input logic           pipe1_issue,
  input logic           core_idle
);
  assert_no_back_to_back_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((grant_onehot & $past(grant_onehot)) == '0));

  assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_onehot) && (core_idle == (grant_onehot == '0)));

  assert_grant_id_R6: assert property (@(posedge clk) disable iff (rst)
    (grant_onehot != '0) |-> grant_onehot[grant_id]);

  assert_pipe0_matches_R7: assert property (@(posedge clk) disable iff (rst)
    pipe0_issue == (grant_onehot != '0));

  assert_pipe1_needs_dual_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && pipe1_issue) |-> (pipe0_issue && (($past(thr_dual) & grant_onehot) != '0)));

  assert_only_ready_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && grant_onehot != '0) |-> (($past(thr_ready) & grant_onehot) != '0));

  assert_busy_when_two_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($countones($past(thr_ready)) >= 2)) |-> (grant_onehot != '0));
endmodule

bind ts_issue_sched ts_issue_sched_chk #(.N(NUM_THREADS), .IDW(IDW)) u_chk (
  .clk(clk), .rst(rst), .thr_ready(thr_ready), .thr_dual(thr_dual),
  .grant_onehot(grant_onehot), .grant_id(grant_id), .pipe0_issue(pipe0_issue),
  .pipe1_issue(pipe1_issue), .core_idle(core_idle)
);

// File: tb/sim_ts_issue_sched.sv
`timescale 1ns/1ps
module sim_ts_issue_sched;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] thr_ready = '0;
  logic [N-1:0] thr_dual  = '0;
  logic [N-1:0] grant_onehot;
  logic [1:0]   grant_id;
  logic         pipe0_issue, pipe1_issue, core_idle;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state
  int m_ptr  = N - 1;
  bit m_bar  = 1'b0;
  logic [N-1:0] prev_grant = '0;

  always #4 clk = ~clk;

  ts_issue_sched u0 (
    .clk(clk), .rst(rst), .thr_ready(thr_ready), .thr_dual(thr_dual),
    .grant_onehot(grant_onehot), .grant_id(grant_id), .pipe0_issue(pipe0_issue),
    .pipe1_issue(pipe1_issue), .core_idle(core_idle)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_ptr = N - 1;
    m_bar = 1'b0;
    prev_grant = '0;
  endtask

  // one cycle: drive, let the edge decide, compare with the rotation model
  task automatic step(input logic [N-1:0] r, input logic [N-1:0] d);
    int win;
    logic [N-1:0] exp_g;
    @(negedge clk);
    thr_ready = r;
    thr_dual  = d;
    @(posedge clk);
    #1;
    win = -1;
    for (int off = 1; off <= N; off++) begin
      int t;
      t = (m_ptr + off) % N;
      if (win < 0 && r[t] && !(m_bar && t == m_ptr)) win = t;
    end
    exp_g = (win >= 0) ? (N'(1) << win) : '0;
    check(grant_onehot == exp_g, "R2 grant order", grant_onehot, exp_g);
    if (win >= 0) check(grant_id == 2'(win), "R6 grant index", grant_id, win);
    check(core_idle == (win < 0), "R6 idle flag", core_idle, win < 0);
    check(pipe0_issue == (win >= 0), "R7 pipe0 strobe", pipe0_issue, win >= 0);
    check(pipe1_issue == (win >= 0 && d[win]), "R7 pipe1 strobe", pipe1_issue,
          win >= 0 && d[win]);
    check((grant_onehot & prev_grant) == '0, "R3 back-to-back", grant_onehot, 0);
    check((grant_onehot & ~r) == '0, "R8 unready granted", grant_onehot, 0);
    if ($countones(r) >= 2) check(grant_onehot != '0, "R5 busy slot", grant_onehot, 1);
    if (win >= 0) begin
      m_ptr = win;
      m_bar = 1'b1;
    end else begin
      m_bar = 1'b0;
    end
    prev_grant = grant_onehot;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check(grant_onehot == '0, "R1 reset grant", grant_onehot, 0);
    check(grant_id == '0, "R1 reset id", grant_id, 0);
    check(!pipe0_issue && !pipe1_issue, "R1 reset strobes", {pipe0_issue, pipe1_issue}, 0);
    check(core_idle, "R1 reset idle", core_idle, 1);
    @(negedge clk);
    rst = 1'b0;
    model_reset();

    // R2: after reset, context 0 goes first with all ready
    step(4'hF, 4'h0);
    check(grant_onehot == 4'b0001, "R2 first after reset", grant_onehot, 1);
    for (int i = 0; i < 7; i++) step(4'hF, 4'hF);

    // R4: lone ready context alternates with idle cycles
    for (int t = 0; t < N; t++) begin
      bit saw_grant;
      step('0, '0);
      step(N'(1) << t, '0);
      saw_grant = grant_onehot[t];
      check(saw_grant, "R4 lone grant", grant_onehot, 1 << t);
      for (int c = 0; c < 5; c++) begin
        step(N'(1) << t, N'(1) << t);
        check(grant_onehot[t] == !saw_grant, "R4 alternation", grant_onehot[t], !saw_grant);
        saw_grant = grant_onehot[t];
      end
    end

    // R9: idle keeps pointer and lifts the bar
    step('0, '0);
    step(4'b0010, '0);
    step('0, '0);
    step(4'b0010, '0);
    check(grant_onehot == 4'b0010, "R9 regrant after idle", grant_onehot, 2);
    step('0, '0);
    step(4'hF, '0);
    check(grant_onehot == 4'b0100, "R9 pointer held", grant_onehot, 4);

    // exhaustive sweep over ready and dual patterns
    for (int r = 0; r < 16; r++)
      for (int d = 0; d < 16; d++)
        step(4'(r), 4'(d));
    for (int d = 0; d < 16; d++)
      for (int r = 15; r >= 0; r--)
        step(4'(r), 4'(d));

    // R1: reset mid-run returns the pointer to 3
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check(core_idle && grant_onehot == '0, "R1 mid-run reset", grant_onehot, 0);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    step(4'b1001, '0);
    check(grant_onehot == 4'b0001, "R2 pointer after reset", grant_onehot, 1);
    step(4'b1001, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule